// File: doc/BRIEF.md
# Serial Channel Register Interface

This block is the processor-facing register file of a two-channel serial controller. A byte bus reaches four locations, one control port and one data port for each of the two channels. Control writes go through a 3-bit register pointer kept in the first write register. Writing the pointer and a command field in the same byte either selects the register that the next control access uses or triggers a side-effect command. Once any register other than the pointer register has been written, the pointer falls back to zero by itself. Control reads at pointer zero return a status byte. That byte merges local flags, the synchronized modem inputs and the live interrupt line.

The serial shifter sits outside this block. The shifter hands in received bytes with a load strobe and reports that a transmit byte has left with a done strobe. The block drives DTR and RTS straight from register bits. It passes CTS and DCD through two synchronizing flops and detects changes on them. It emits one-cycle set and clear strobes for four interrupt sources per channel toward an external interrupt controller. The address decoder supports two bit orders, chosen by a static strap input.

Top module: `serial_regif`

## Requirements
- R1: With `addr_swap_i`=0, address bit 1 high selects the control port and bit 0 high selects channel B. With `addr_swap_i`=1 the roles swap: bit 0 high selects control and bit 1 high selects channel B. Channel A is index 0 and channel B is index 1 on every per-channel port.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. A control write while the pointer is nonzero updates that register and returns the pointer to 0. A control read while the pointer is nonzero returns 0x00.
- R3: A control read at pointer 0 returns this status byte: bit 0 receive character available, bit 1 the live level of `irq_i`, bit 2 transmit buffer empty, bit 3 DCD, bit 5 CTS. All other bits read 0. Outside a read, `rdata_o` is 0x00.
- R4: Register 5 bit 7 drives `dtr_o` and register 5 bit 1 drives `rts_o`. Register 5 bit 3 is transmit enable. Register 1 bit 0 enables external/status interrupts, register 1 bit 1 enables transmit interrupts and register 1 bits 4:3 select the receive interrupt mode. Register 3 bit 0 enables receive.
- R5: A pointer-0 control write carries a command in bits 5:3. Code 010 pulses the external/status clear, 101 the transmit clear and 110 the error clear. Code 100 arms the next-receive interrupt. Codes 000, 001 and 111 have no effect.
- R6: Command 011 resets the channel. Status becomes transmit-empty only, so CTS and DCD status and receive-available read 0. The arm flag is cleared and all four clear strobes of that channel pulse. The write registers and modem outputs are kept.
- R7: A data write while transmit enable is 0 changes nothing. With transmit enable 1 it loads `tx_data_o` on the next edge, clears transmit-empty and pulses the transmit clear strobe.
- R8: A data read returns the last received byte, clears receive-available and pulses the receive clear strobe.
- R9: `rx_load_i` is ignored while receive is disabled. When receive is enabled it stores the byte and sets receive-available. The receive set strobe pulses in two cases: for mode 10 or 11, and for mode 01 only when the channel is armed. Each accepted byte clears the arm.
- R10: `tx_done_i` sets transmit-empty. It pulses the transmit set strobe when the transmit interrupt is enabled.
- R11: CTS and DCD reach status two clocks after they are sampled. A change raises the external/status set strobe only if the new level differs from the status bit and register 1 bit 0 is set.
- R12: Strobe bit 4*channel+source carries the strobe for that channel and source, with sources transmit=0, external/status=1, receive=2, error=3. A set strobe takes precedence over a clear strobe of the same source.
- R13: After reset both channels read status 0x04 with `irq_i` low, and all outputs other than status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_swap_i | input | 1 | Selects the alternate address bit order |
| addr_i | input | 2 | Port address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_i` |
| irq_i | input | 1 | Live interrupt line from the interrupt controller |
| cts_i | input | 2 | Asynchronous CTS per channel |
| dcd_i | input | 2 | Asynchronous DCD per channel |
| dtr_o | output | 2 | DTR per channel |
| rts_o | output | 2 | RTS per channel |
| rx_load_i | input | 2 | Received byte strobe per channel |
| rx_data_i | input | 16 | Received bytes, channel B in the upper byte |
| tx_done_i | input | 2 | Transmit byte consumed per channel |
| tx_data_o | output | 16 | Transmit byte per channel |
| int_set_o | output | 8 | Interrupt set strobes |
| int_clr_o | output | 8 | Interrupt clear strobes |

## Verification
If the pointer is left wrong, the very next control access shows it: a read returns 0x00 where status was due, or a write lands in the wrong register, and that shows one cycle later on `dtr_o`, `rts_o` or a gating decision. A wrong status flag shows at the next RR0 read. A wrong enable or arm bit shows as a missing or extra set or clear strobe in the same cycle as the triggering event. The bench runs a behavioural model alongside the design and compares every output on every clock. It therefore catches a divergence in the cycle it first reaches a port, including synchronizer latency errors on the modem inputs.

// File: rtl/regif_pkg.sv
package regif_pkg;
  localparam int NUM_CH   = 2;
  localparam int NUM_SRC  = 4;
  localparam int PTR_W    = 3;

  typedef enum logic [1:0] {
    SRC_TX  = 2'd0,
    SRC_EXT = 2'd1,
    SRC_RX  = 2'd2,
    SRC_ERR = 2'd3
  } int_src_e;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'b000,
    CMD_ABORT  = 3'b001,
    CMD_EXTCLR = 3'b010,
    CMD_CHRST  = 3'b011,
    CMD_ARMRX  = 3'b100,
    CMD_TXCLR  = 3'b101,
    CMD_ERRCLR = 3'b110,
    CMD_RET    = 3'b111
  } cmd_e;

  localparam logic [PTR_W-1:0] REG_IE   = 3'd1;
  localparam logic [PTR_W-1:0] REG_RXC  = 3'd3;
  localparam logic [PTR_W-1:0] REG_TXC  = 3'd5;
endpackage

// File: rtl/regif_addr_dec.sv
module regif_addr_dec (
  input  logic       swap_i,
  input  logic [1:0] addr_i,
  output logic       ctrl_o,
  output logic       chan_o
);
  // swap_i exchanges the meaning of the two address bits
  assign ctrl_o = swap_i ? addr_i[0] : addr_i[1];
  assign chan_o = swap_i ? addr_i[1] : addr_i[0];
endmodule

// File: rtl/regif_modem_sync.sv
module regif_modem_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign lvl_o[b] = chain_q[STAGES-1];
    assign chg_o[b] = chain_q[STAGES-1] ^ prev_q;
  end
endmodule

// File: rtl/regif_channel.sv
module regif_channel
  import regif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cwr_i,
  input  logic               crd_i,
  input  logic               dwr_i,
  input  logic               drd_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               irq_i,
  input  logic               cts_lvl_i,
  input  logic               cts_chg_i,
  input  logic               dcd_lvl_i,
  input  logic               dcd_chg_i,
  input  logic               rx_load_i,
  input  logic [DW-1:0]      rx_data_i,
  input  logic               tx_done_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NUM_SRC-1:0] int_set_o,
  output logic [NUM_SRC-1:0] int_clr_o,
  output logic               dtr_o,
  output logic               rts_o,
  output logic [DW-1:0]      tx_data_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             ext_ie_q, tx_ie_q, rx_en_q, tx_en_q, dtr_q, rts_q;
  logic [1:0]       rx_mode_q;
  logic             rx_avail_q, tx_empty_q, cts_q, dcd_q, arm_q;
  logic [DW-1:0]    rxbuf_q, txbuf_q;

  logic             is_cmd, do_rst, ext_ev, rx_accept, tx_accept;
  cmd_e             cmd;
  logic [NUM_SRC-1:0] set_raw, clr_raw;

  assign cmd       = cmd_e'(wdata_i[5:3]);
  assign is_cmd    = cwr_i && (ptr_q == '0);
  assign do_rst    = is_cmd && (cmd == CMD_CHRST);
  assign rx_accept = rx_load_i && rx_en_q;
  assign tx_accept = dwr_i && tx_en_q;
  assign ext_ev    = (cts_chg_i && (cts_lvl_i != cts_q)) ||
                     (dcd_chg_i && (dcd_lvl_i != dcd_q));

  always_comb begin
    set_raw          = '0;
    set_raw[SRC_TX]  = tx_done_i && tx_ie_q;
    set_raw[SRC_EXT] = ext_ev && ext_ie_q;
    set_raw[SRC_RX]  = rx_accept && (rx_mode_q[1] || (rx_mode_q == 2'b01 && arm_q));
    clr_raw          = '0;
    clr_raw[SRC_TX]  = (is_cmd && cmd == CMD_TXCLR) || tx_accept;
    clr_raw[SRC_EXT] = is_cmd && cmd == CMD_EXTCLR;
    clr_raw[SRC_RX]  = drd_i;
    clr_raw[SRC_ERR] = is_cmd && cmd == CMD_ERRCLR;
    if (do_rst) begin
      set_raw = '0;
      clr_raw = '1;
    end
  end

  assign int_set_o = set_raw;
  assign int_clr_o = clr_raw & ~set_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      ext_ie_q   <= 1'b0;
      tx_ie_q    <= 1'b0;
      rx_mode_q  <= 2'b00;
      rx_en_q    <= 1'b0;
      tx_en_q    <= 1'b0;
      dtr_q      <= 1'b0;
      rts_q      <= 1'b0;
      rx_avail_q <= 1'b0;
      tx_empty_q <= 1'b1;
      cts_q      <= 1'b0;
      dcd_q      <= 1'b0;
      arm_q      <= 1'b0;
      rxbuf_q    <= '0;
      txbuf_q    <= '0;
    end else begin
      if (cwr_i) begin
        if (ptr_q == '0) begin
          ptr_q <= wdata_i[PTR_W-1:0];
        end else begin
          ptr_q <= '0;
          case (ptr_q)
            REG_IE: begin
              ext_ie_q  <= wdata_i[0];
              tx_ie_q   <= wdata_i[1];
              rx_mode_q <= wdata_i[4:3];
            end
            REG_RXC: rx_en_q <= wdata_i[0];
            REG_TXC: begin
              dtr_q   <= wdata_i[7];
              tx_en_q <= wdata_i[3];
              rts_q   <= wdata_i[1];
            end
            default: ;
          endcase
        end
      end
      if (is_cmd && cmd == CMD_ARMRX) arm_q <= 1'b1;
      if (rx_accept) begin
        rxbuf_q    <= rx_data_i;
        rx_avail_q <= 1'b1;
        arm_q      <= 1'b0;
      end else if (drd_i) begin
        rx_avail_q <= 1'b0;
      end
      if (tx_accept) begin
        txbuf_q    <= wdata_i;
        tx_empty_q <= 1'b0;
      end else if (tx_done_i) begin
        tx_empty_q <= 1'b1;
      end
      if (cts_chg_i) cts_q <= cts_lvl_i;
      if (dcd_chg_i) dcd_q <= dcd_lvl_i;
      if (do_rst) begin
        tx_empty_q <= 1'b1;
        rx_avail_q <= 1'b0;
        arm_q      <= 1'b0;
        cts_q      <= 1'b0;
        dcd_q      <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (crd_i) begin
      if (ptr_q == '0) begin
        rdata_o[0] = rx_avail_q;
        rdata_o[1] = irq_i;
        rdata_o[2] = tx_empty_q;
        rdata_o[3] = dcd_q;
        rdata_o[5] = cts_q;
      end
    end else if (drd_i) begin
      rdata_o = rxbuf_q;
    end
  end

  assign dtr_o     = dtr_q;
  assign rts_o     = rts_q;
  assign tx_data_o = txbuf_q;

  // R2
  ptr_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cwr_i && ptr_q != '0) |=> (ptr_q == '0));
  // R7
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwr_i && !tx_en_q) |=> $stable(tx_data_o));
  // R8
  rd_clears_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drd_i && !rx_load_i) |=> !rx_avail_q);
  // R6
  chan_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_rst |=> (tx_empty_q && !rx_avail_q && !arm_q && !cts_q && !dcd_q));
  // R11
  cts_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_chg_i && !do_rst) |=> (cts_q == $past(cts_lvl_i)));
endmodule

// File: rtl/serial_regif.sv
module serial_regif
  import regif_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    addr_swap_i,
  input  logic [1:0]              addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  input  logic                    irq_i,
  input  logic [NUM_CH-1:0]       cts_i,
  input  logic [NUM_CH-1:0]       dcd_i,
  output logic [NUM_CH-1:0]       dtr_o,
  output logic [NUM_CH-1:0]       rts_o,
  input  logic [NUM_CH-1:0]       rx_load_i,
  input  logic [NUM_CH*DW-1:0]    rx_data_i,
  input  logic [NUM_CH-1:0]       tx_done_i,
  output logic [NUM_CH*DW-1:0]    tx_data_o,
  output logic [NUM_CH*NUM_SRC-1:0] int_set_o,
  output logic [NUM_CH*NUM_SRC-1:0] int_clr_o
);
  logic          sel_ctrl, sel_ch;
  logic [DW-1:0] ch_rdata [NUM_CH];

  regif_addr_dec i_dec (
    .swap_i (addr_swap_i),
    .addr_i (addr_i),
    .ctrl_o (sel_ctrl),
    .chan_o (sel_ch)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic       hit;
    logic [1:0] lvl, chg;
    assign hit = (sel_ch == c[0]);

    regif_modem_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i ({dcd_i[c], cts_i[c]}),
      .lvl_o   (lvl),
      .chg_o   (chg)
    );

    regif_channel #(.DW(DW)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cwr_i     (wr_i && hit && sel_ctrl),
      .crd_i     (rd_i && hit && sel_ctrl),
      .dwr_i     (wr_i && hit && !sel_ctrl),
      .drd_i     (rd_i && hit && !sel_ctrl),
      .wdata_i   (wdata_i),
      .irq_i     (irq_i),
      .cts_lvl_i (lvl[0]),
      .cts_chg_i (chg[0]),
      .dcd_lvl_i (lvl[1]),
      .dcd_chg_i (chg[1]),
      .rx_load_i (rx_load_i[c]),
      .rx_data_i (rx_data_i[c*DW +: DW]),
      .tx_done_i (tx_done_i[c]),
      .rdata_o   (ch_rdata[c]),
      .int_set_o (int_set_o[c*NUM_SRC +: NUM_SRC]),
      .int_clr_o (int_clr_o[c*NUM_SRC +: NUM_SRC]),
      .dtr_o     (dtr_o[c]),
      .rts_o     (rts_o[c]),
      .tx_data_o (tx_data_o[c*DW +: DW])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) rdata_o |= ch_rdata[c];
  end

  // R12
  set_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int_set_o & int_clr_o) == '0));
  // R3
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/test_serial_regif.sv
module test_serial_regif;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic swap = 0, wr = 0, rd = 0, irq = 0;
  logic [1:0] addr = 0, cts = 0, dcd = 0, rx_load = 0, tx_done = 0;
  logic [7:0] wdata = 0, rdata;
  logic [15:0] rx_data = 0, tx_data;
  logic [1:0] dtr, rts;
  logic [7:0] iset, iclr;

  serial_regif i_serial_regif (
    .clk_i(clk), .rst_ni(rst_n), .addr_swap_i(swap), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq),
    .cts_i(cts), .dcd_i(dcd), .dtr_o(dtr), .rts_o(rts),
    .rx_load_i(rx_load), .rx_data_i(rx_data), .tx_done_i(tx_done),
    .tx_data_o(tx_data), .int_set_o(iset), .int_clr_o(iclr));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R13";

  // behavioural model state
  int m_ptr[2], m_mode[2];
  bit m_extie[2], m_txie[2], m_rxen[2], m_txen[2], m_dtr[2], m_rts[2];
  bit m_rxa[2], m_txe[2], m_cts[2], m_dcd[2], m_arm[2];
  logic [7:0] m_rxb[2], m_txb[2];
  bit hc[2][3], hd[2][3];

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ptr[c] = 0; m_mode[c] = 0; m_extie[c] = 0; m_txie[c] = 0; m_rxen[c] = 0;
      m_txen[c] = 0; m_dtr[c] = 0; m_rts[c] = 0; m_rxa[c] = 0; m_txe[c] = 1;
      m_cts[c] = 0; m_dcd[c] = 0; m_arm[c] = 0; m_rxb[c] = 0; m_txb[c] = 0;
      for (int k = 0; k < 3; k++) begin hc[c][k] = 0; hd[c][k] = 0; end
    end
  endtask

  // one clock: compare outputs against the model, then advance the model
  task automatic step();
    bit ctrl, ch;
    logic [7:0] e_rd, e_set, e_clr;
    bit cwr[2], crd[2], dwr[2], drd[2], cmdw[2], rst[2], ev[2];
    int cmd;
    #2;
    ctrl = swap ? addr[0] : addr[1];
    ch   = swap ? addr[1] : addr[0];
    cmd  = wdata[5:3];
    e_rd = 0; e_set = 0; e_clr = 0;
    for (int c = 0; c < 2; c++) begin
      logic [3:0] s, k;
      cwr[c] = wr && ctrl && ch == c; crd[c] = rd && ctrl && ch == c;
      dwr[c] = wr && !ctrl && ch == c; drd[c] = rd && !ctrl && ch == c;
      cmdw[c] = cwr[c] && m_ptr[c] == 0;
      rst[c] = cmdw[c] && cmd == 3;
      ev[c] = ((hc[c][1] != hc[c][2]) && hc[c][1] != m_cts[c]) ||
              ((hd[c][1] != hd[c][2]) && hd[c][1] != m_dcd[c]);
      s = 0; k = 0;
      s[0] = tx_done[c] && m_txie[c];
      s[1] = ev[c] && m_extie[c];
      s[2] = rx_load[c] && m_rxen[c] && (m_mode[c] >= 2 || (m_mode[c] == 1 && m_arm[c]));
      k[0] = (cmdw[c] && cmd == 5) || (dwr[c] && m_txen[c]);
      k[1] = cmdw[c] && cmd == 2;
      k[2] = drd[c];
      k[3] = cmdw[c] && cmd == 6;
      if (rst[c]) begin s = 0; k = 4'hF; end
      k = k & ~s;
      e_set[c*4 +: 4] = s; e_clr[c*4 +: 4] = k;
      if (crd[c] && m_ptr[c] == 0)
        e_rd = {2'b00, m_cts[c], 1'b0, m_dcd[c], m_txe[c], irq, m_rxa[c]};
      else if (drd[c]) e_rd = m_rxb[c];
    end
    chk("rdata", {8'h0, rdata}, {8'h0, e_rd});
    chk("int_set", {8'h0, iset}, {8'h0, e_set});
    chk("int_clr", {8'h0, iclr}, {8'h0, e_clr});
    chk("dtr/rts", {12'h0, dtr, rts}, {12'h0, m_dtr[1], m_dtr[0], m_rts[1], m_rts[0]});
    chk("tx_data", tx_data, {m_txb[1], m_txb[0]});
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (cwr[c]) begin
        if (m_ptr[c] == 0) m_ptr[c] = wdata[2:0];
        else begin
          if (m_ptr[c] == 1) begin
            m_extie[c] = wdata[0]; m_txie[c] = wdata[1]; m_mode[c] = wdata[4:3];
          end else if (m_ptr[c] == 3) m_rxen[c] = wdata[0];
          else if (m_ptr[c] == 5) begin
            m_dtr[c] = wdata[7]; m_txen[c] = wdata[3]; m_rts[c] = wdata[1];
          end
          m_ptr[c] = 0;
        end
      end
      if (cmdw[c] && cmd == 4) m_arm[c] = 1;
      if (rx_load[c] && m_rxen[c]) begin
        m_rxb[c] = rx_data[c*8 +: 8]; m_rxa[c] = 1; m_arm[c] = 0;
      end else if (drd[c]) m_rxa[c] = 0;
      if (dwr[c] && m_txen[c]) begin m_txb[c] = wdata; m_txe[c] = 0; end
      else if (tx_done[c]) m_txe[c] = 1;
      if (hc[c][1] != hc[c][2]) m_cts[c] = hc[c][1];
      if (hd[c][1] != hd[c][2]) m_dcd[c] = hd[c][1];
      if (rst[c]) begin m_txe[c] = 1; m_rxa[c] = 0; m_arm[c] = 0; m_cts[c] = 0; m_dcd[c] = 0; end
      hc[c][2] = hc[c][1]; hc[c][1] = hc[c][0]; hc[c][0] = cts[c];
      hd[c][2] = hd[c][1]; hd[c][1] = hd[c][0]; hd[c][0] = dcd[c];
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1; step(); wr = 0; wdata = 0;
  endtask

  task automatic bus_rd(logic [1:0] a);
    addr = a; rd = 1; step(); rd = 0;
  endtask

  // standard map addresses
  localparam logic [1:0] CA = 2'b10, CB = 2'b11, DA = 2'b00, DB = 2'b01;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R13";
    idle(1); bus_rd(CA); bus_rd(CB);
    phase = "R4";
    bus_wr(CA, 8'h05); bus_wr(CA, 8'h8A);
    bus_wr(CB, 8'h05); bus_wr(CB, 8'h02);
    phase = "R1";
    swap = 1;
    bus_wr(2'b11, 8'h05); bus_wr(2'b11, 8'h88);
    bus_wr(2'b01, 8'h03); bus_wr(2'b01, 8'h01);
    bus_rd(2'b01); bus_rd(2'b11);
    swap = 0;
    phase = "R2";
    bus_wr(CA, 8'h01); bus_rd(CA); bus_wr(CA, 8'h02);
    bus_rd(CA); bus_wr(CA, 8'h06); bus_wr(CA, 8'hFF); bus_rd(CA);
    phase = "R7";
    bus_wr(CB, 8'h05); bus_wr(CB, 8'h00);
    bus_wr(DB, 8'h77); bus_rd(CB);
    bus_wr(DA, 8'h5A); bus_rd(CA);
    phase = "R10";
    bus_wr(CA, 8'h01); bus_wr(CA, 8'h0A);
    tx_done = 2'b01; step(); tx_done = 0; bus_rd(CA);
    phase = "R9";
    bus_wr(CB, 8'h01); bus_wr(CB, 8'h08);
    rx_data = 16'h3300; rx_load = 2'b10; step(); rx_load = 0; bus_rd(CB);
    bus_wr(CB, 8'h03); bus_wr(CB, 8'h01);
    rx_data = 16'h4400; rx_load = 2'b10; step(); rx_load = 0;
    bus_wr(CB, 8'h20);
    rx_data = 16'h5500; rx_load = 2'b10; step();
    rx_data = 16'h6600; step(); rx_load = 0;
    bus_wr(CB, 8'h01); bus_wr(CB, 8'h10);
    rx_data = 16'h7700; rx_load = 2'b10; step(); step(); rx_load = 0;
    phase = "R8";
    bus_rd(CB); bus_rd(DB); bus_rd(CB);
    rx_data = 16'h00C3; rx_load = 2'b01; step(); rx_load = 0;
    bus_rd(DA); bus_rd(CA);
    phase = "R3";
    irq = 1; bus_rd(CA); bus_rd(CB); irq = 0; bus_rd(CA);
    phase = "R11";
    cts = 2'b10; idle(4); bus_rd(CB);
    bus_wr(CB, 8'h01); bus_wr(CB, 8'h19);
    cts = 2'b00; idle(4); dcd = 2'b11; idle(4); bus_rd(CB); bus_rd(CA);
    phase = "R5";
    bus_wr(CB, 8'h10); bus_wr(CA, 8'h28); bus_wr(CA, 8'h30);
    bus_wr(CA, 8'h08); bus_wr(CA, 8'h38); bus_wr(CA, 8'h00);
    phase = "R12";
    bus_wr(CB, 8'h30); bus_wr(CB, 8'h28);
    tx_done = 2'b11; step(); tx_done = 0;
    phase = "R6";
    bus_wr(CA, 8'h20); bus_wr(CA, 8'h18); bus_rd(CA); bus_wr(CB, 8'h18);
    bus_rd(CB); dcd = 2'b00; idle(4); bus_rd(CB);
    rx_data = 16'h0011; rx_load = 2'b01; step(); rx_load = 0;
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule